// File: doc/BRIEF.md
# All-Ones Alarm Detector

This block watches a recovered receive bit stream and flags the all-ones alarm condition that a far end sends when it has no valid traffic. It cuts the stream into consecutive observation windows of a fixed number of bit periods and counts the zero bits inside each window. A window with very few zeros raises the alarm. A window with clearly more zeros drops it. A window that lands between the two limits keeps the alarm as it was. This gap between the set and clear limits gives the flag hysteresis, so a stream that sits on the edge does not make it chatter.

Bits are qualified by a bit-clock enable, so the block runs from a fast system clock and counts only the cycles that carry a received bit. A mode enable switches the detector on. While the mode is off, the flag stays low and the window keeps restarting. The flag changes only when a window closes. All state is cleared by a synchronous reset.

Top module: `ais_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `alarm` low after that edge and restarts the window, so the next window closes on the WINDOW_BITS-th (2048) accepted bit after reset is released.
- R2: A window spans exactly WINDOW_BITS (default 2048) accepted bits, and windows follow each other back to back. `alarm` can change only on the edge that accepts the last bit of a window. It holds its value on every other edge while the mode is on.
- R3: A zero bit is `rx_bit` = 0. If a window closes with fewer than SET_BELOW (3) zeros, that is 0, 1 or 2 zeros, `alarm` is high after the closing edge.
- R4: If a window closes with CLEAR_AT (4) or more zeros, `alarm` is low after the closing edge. This holds for any larger count as well.
- R5: If a window closes with exactly 3 zeros (at least SET_BELOW and fewer than CLEAR_AT), `alarm` keeps its previous value, whether that value is high or low.
- R6: Cycles with `bit_en` low are ignored. Their `rx_bit` is not counted, and they do not advance the window position.
- R7: While `mode_en` is low, `alarm` is low from the next edge, no bits are counted, and the window restarts. A new window begins at the first accepted bit after `mode_en` returns high.
- R8: Zeros are not carried from one window into the next. Each window is judged only on the zeros among its own bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | High in cycles that carry one received bit |
| rx_bit | input | 1 | Received data bit, sampled when bit_en is high |
| mode_en | input | 1 | Detector enable; low holds the alarm low and restarts the window |
| alarm | output | 1 | All-ones alarm flag, registered |

## Verification
Directed windows carry exactly 0, 1, 2, 3, 4 and 5 zeros. The 3-zero window is run once while the flag is high and once while it is low, which separates hold behaviour from a single-threshold design. One pair of windows puts two zeros at the tail of one window and two at the head of the next: a counter that leaks across the boundary clears the flag, while a correct one keeps it high. Idle cycles carrying zeros, partial windows cut short by reset or by dropping the mode, and random windows with random zero counts and idle gaps check the window position and qualification against a bench model of the hysteresis rule.

// File: rtl/ais_pkg.sv
package ais_pkg;

   typedef enum logic [1:0] {
      AIS_KEEP  = 2'd0,
      AIS_RAISE = 2'd1,
      AIS_DROP  = 2'd2
   } ais_verdict_e;

   // Decide the flag action from the zero count of a closed window.
   function automatic ais_verdict_e ais_judge(input int unsigned zeros,
                                              input int unsigned set_below,
                                              input int unsigned clear_at);
      if (zeros < set_below)
         return AIS_RAISE;
      else if (zeros >= clear_at)
         return AIS_DROP;
      else
         return AIS_KEEP;
   endfunction

endpackage

// File: rtl/ais_window_ctr.sv
module ais_window_ctr #(
   parameter int unsigned WINDOW_BITS = 2048
) (
   input  logic clk,
   input  logic clr,
   input  logic step,
   output logic at_last
);
   localparam int unsigned POS_W = (WINDOW_BITS > 2) ? $clog2(WINDOW_BITS) : 1;
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(WINDOW_BITS - 1);
   localparam bit IS_POW2 = ((WINDOW_BITS & (WINDOW_BITS - 1)) == 0);

   logic [POS_W-1:0] pos_q;

   assign at_last = (pos_q == LAST_POS);

   generate
      if (IS_POW2) begin : g_wrap_free
         always_ff @(posedge clk) begin
            if (clr)
               pos_q <= '0;
            else if (step)
               pos_q <= pos_q + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk) begin
            if (clr)
               pos_q <= '0;
            else if (step)
               pos_q <= at_last ? '0 : pos_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/ais_zero_ctr.sv
module ais_zero_ctr #(
   parameter int unsigned SAT_MAX = 4
) (
   input  logic clk,
   input  logic clr,
   input  logic step,
   input  logic wrap,
   input  logic is_zero,
   output logic [$clog2(SAT_MAX+1)-1:0] total
);
   localparam int unsigned ZC_W = $clog2(SAT_MAX + 1);
   localparam logic [ZC_W-1:0] SAT_VAL = ZC_W'(SAT_MAX);

   logic [ZC_W-1:0] cnt_q;
   logic [ZC_W:0]   sum;

   // Count including the bit being accepted this cycle, saturated.
   always_comb begin
      sum   = {1'b0, cnt_q} + {{ZC_W{1'b0}}, is_zero};
      total = (sum >= {1'b0, SAT_VAL}) ? SAT_VAL : sum[ZC_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (clr)
         cnt_q <= '0;
      else if (step)
         cnt_q <= wrap ? '0 : total;
   end

endmodule

// File: rtl/ais_flag_reg.sv
module ais_flag_reg
   import ais_pkg::*;
(
   input  logic         clk,
   input  logic         clr,
   input  logic         update,
   input  ais_verdict_e verdict,
   output logic         flag
);
   always_ff @(posedge clk) begin
      if (clr)
         flag <= 1'b0;
      else if (update) begin
         case (verdict)
            AIS_RAISE: flag <= 1'b1;
            AIS_DROP:  flag <= 1'b0;
            default:   flag <= flag;
         endcase
      end
   end

endmodule

// File: rtl/ais_detector.sv
module ais_detector
   import ais_pkg::*;
#(
   parameter int unsigned WINDOW_BITS = 2048,
   parameter int unsigned SET_BELOW   = 3,
   parameter int unsigned CLEAR_AT    = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic rx_bit,
   input  logic mode_en,
   output logic alarm
);
   localparam int unsigned ZC_W = $clog2(CLEAR_AT + 1);

   generate
      if (WINDOW_BITS < 2) begin : g_bad_window
         $error("ais_detector: WINDOW_BITS must be at least 2");
      end
      if (SET_BELOW < 1) begin : g_bad_set
         $error("ais_detector: SET_BELOW must be at least 1");
      end
      if (CLEAR_AT < SET_BELOW) begin : g_bad_clear
         $error("ais_detector: CLEAR_AT must not be below SET_BELOW");
      end
      if (CLEAR_AT > WINDOW_BITS) begin : g_bad_reach
         $error("ais_detector: CLEAR_AT cannot exceed WINDOW_BITS");
      end
   endgenerate

   logic            restart;
   logic            step;
   logic            at_last;
   logic            wrap;
   logic [ZC_W-1:0] zeros_total;
   ais_verdict_e    verdict;

   assign restart = rst | ~mode_en;
   assign step    = bit_en & mode_en;
   assign wrap    = step & at_last;
   assign verdict = ais_judge(32'(zeros_total), SET_BELOW, CLEAR_AT);

   ais_window_ctr #(
      .WINDOW_BITS(WINDOW_BITS)
   ) u_window (
      .clk     (clk),
      .clr     (restart),
      .step    (step),
      .at_last (at_last)
   );

   ais_zero_ctr #(
      .SAT_MAX(CLEAR_AT)
   ) u_zeros (
      .clk     (clk),
      .clr     (restart),
      .step    (step),
      .wrap    (wrap),
      .is_zero (~rx_bit),
      .total   (zeros_total)
   );

   ais_flag_reg u_flag (
      .clk     (clk),
      .clr     (restart),
      .update  (wrap),
      .verdict (verdict),
      .flag    (alarm)
   );

endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk #(
   parameter int unsigned WINDOW_BITS = 2048,
   parameter int unsigned SET_BELOW   = 3,
   parameter int unsigned CLEAR_AT    = 4
) (
   input logic clk,
   input logic rst,
   input logic bit_en,
   input logic rx_bit,
   input logic mode_en,
   input logic alarm
);
   // Independent bookkeeping of window position and raw zero count.
   int unsigned pos_c;
   int unsigned zc_c;
   int unsigned zeros_now;
   logic        take;
   logic        closing;

   assign take      = bit_en & mode_en;
   assign closing   = take & (pos_c == WINDOW_BITS - 1);
   assign zeros_now = zc_c + {31'd0, ~rx_bit};

   always_ff @(posedge clk) begin
      if (rst || !mode_en) begin
         pos_c <= 0;
         zc_c  <= 0;
      end else if (take) begin
         pos_c <= closing ? 0 : pos_c + 1;
         zc_c  <= closing ? 0 : zeros_now;
      end
   end

   AST_RESET_LOW: assert property (@(posedge clk)
      rst |=> !alarm); // R1

   AST_STEADY_MID: assert property (@(posedge clk) disable iff (rst)
      (mode_en && !closing) |=> $stable(alarm)); // R2

   AST_SET_FEW: assert property (@(posedge clk) disable iff (rst)
      (closing && zeros_now < SET_BELOW) |=> alarm); // R3

   AST_CLEAR_MANY: assert property (@(posedge clk) disable iff (rst)
      (closing && zeros_now >= CLEAR_AT) |=> !alarm); // R4

   AST_KEEP_MIDDLE: assert property (@(posedge clk) disable iff (rst)
      (closing && zeros_now >= SET_BELOW && zeros_now < CLEAR_AT) |=> $stable(alarm)); // R5

   AST_MODE_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
      !mode_en |=> !alarm); // R7

endmodule

bind ais_detector ais_detector_chk #(
   .WINDOW_BITS(WINDOW_BITS),
   .SET_BELOW  (SET_BELOW),
   .CLEAR_AT   (CLEAR_AT)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .bit_en  (bit_en),
   .rx_bit  (rx_bit),
   .mode_en (mode_en),
   .alarm   (alarm)
);

// File: tb/test_ais_detector.sv
module test_ais_detector;
   localparam int W = 2048;

   logic clk     = 1'b0;
   logic rst     = 1'b1;
   logic bit_en  = 1'b0;
   logic rx_bit  = 1'b1;
   logic mode_en = 1'b0;
   logic alarm;

   int   checks    = 0;
   int   errors    = 0;
   logic exp_alarm = 1'b0;
   bit   done      = 1'b0;

   always #2 clk = ~clk;

   ais_detector #(
      .WINDOW_BITS(W),
      .SET_BELOW  (3),
      .CLEAR_AT   (4)
   ) i_ais_detector (
      .clk     (clk),
      .rst     (rst),
      .bit_en  (bit_en),
      .rx_bit  (rx_bit),
      .mode_en (mode_en),
      .alarm   (alarm)
   );

   function automatic logic next_alarm(logic prev, int zeros);
      if (zeros < 3) return 1'b1;
      if (zeros >= 4) return 1'b0;
      return prev;
   endfunction

   task automatic check(string req, logic act, logic expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: alarm=%b expected %b", req, act, expv);
      end
   endtask

   task automatic cyc(logic en, logic b, logic m);
      @(negedge clk);
      bit_en  = en;
      rx_bit  = b;
      mode_en = m;
      @(posedge clk);
      #1;
   endtask

   task automatic feed_ones(int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1);
   endtask

   // place: 0 random positions, 1 zeros at the tail, 2 zeros at the head
   task automatic run_window(int k, int place, bit gaps, string req);
      logic [W-1:0] pat;
      pat = '1;
      if (place == 1) begin
         for (int i = 0; i < k; i++) pat[W-1-i] = 1'b0;
      end else if (place == 2) begin
         for (int i = 0; i < k; i++) pat[i] = 1'b0;
      end else begin
         int placed = 0;
         while (placed < k) begin
            int p = $urandom_range(W-1, 0);
            if (pat[p]) begin
               pat[p] = 1'b0;
               placed++;
            end
         end
      end
      for (int i = 0; i < W; i++) begin
         if (gaps && $urandom_range(3, 0) == 0)
            cyc(1'b0, 1'($urandom_range(1, 0)), 1'b1);
         cyc(1'b1, pat[i], 1'b1);
         if (i == 0) check("R2 alarm steady inside window", alarm, exp_alarm);
      end
      exp_alarm = next_alarm(exp_alarm, k);
      check(req, alarm, exp_alarm);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20911));
      repeat (3) cyc(1'b0, 1'b1, 1'b0);
      check("R1 alarm low under reset", alarm, 1'b0);
      @(negedge clk);
      rst = 1'b0;

      run_window(0, 0, 1'b0, "R3 window without zeros sets");
      run_window(3, 0, 1'b1, "R5 three zeros keep high");
      run_window(4, 0, 1'b1, "R4 four zeros clear");
      run_window(3, 0, 1'b0, "R5 three zeros keep low");
      run_window(2, 0, 1'b1, "R3 two zeros set");
      run_window(5, 0, 1'b0, "R4 five zeros clear");
      run_window(1, 0, 1'b0, "R3 one zero sets");

      // R8: two zeros at the tail, two at the head of the next window
      run_window(2, 1, 1'b0, "R8 tail zeros keep set");
      run_window(2, 2, 1'b0, "R8 head zeros not joined with previous");

      // R6: idle cycles carrying zeros are neither counted nor advancing
      run_window(6, 0, 1'b0, "R4 six zeros clear");
      for (int i = 0; i < W - 1; i++) begin
         cyc(1'b0, 1'b0, 1'b1);
         cyc(1'b1, 1'b1, 1'b1);
      end
      repeat (50) cyc(1'b0, 1'b0, 1'b1);
      check("R6 idle cycles do not close window", alarm, 1'b0);
      cyc(1'b1, 1'b1, 1'b1);
      exp_alarm = 1'b1;
      check("R6 idle zeros not counted", alarm, exp_alarm);

      // R7: dropping the mode forces low and restarts the window
      feed_ones(1000);
      cyc(1'b1, 1'b1, 1'b0);
      check("R7 mode off drives alarm low", alarm, 1'b0);
      repeat (4) cyc(1'b1, 1'b0, 1'b0);
      exp_alarm = 1'b0;
      feed_ones(W - 1000);
      check("R7 window restarted after mode on", alarm, 1'b0);
      feed_ones(1000);
      exp_alarm = 1'b1;
      check("R7 full window after mode on", alarm, exp_alarm);

      // R1: reset in mid-window clears and restarts
      feed_ones(500);
      @(negedge clk);
      rst = 1'b1;
      cyc(1'b1, 1'b1, 1'b1);
      rst = 1'b0;
      exp_alarm = 1'b0;
      check("R1 reset clears alarm", alarm, 1'b0);
      feed_ones(W - 500);
      check("R1 window restarted by reset", alarm, 1'b0);
      feed_ones(500);
      exp_alarm = 1'b1;
      check("R1 first window after reset", alarm, exp_alarm);

      // Random windows against the bench model (R3/R4/R5)
      for (int n = 0; n < 12; n++) begin
         int k;
         if ($urandom_range(4, 0) == 0) k = $urandom_range(200, 5);
         else k = $urandom_range(5, 0);
         run_window(k, 0, 1'b1, "R3/R4/R5 random window");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule